// File: doc/BRIEF.md
# Supply-Loss Store and Power-Up Recall Sequencer

This block watches two comparator flags that describe the backup supply of a nonvolatile static memory. One flag is high while the supply is above the switch threshold. The other is high while the supply is above the lower reset threshold. When the supply sinks through the switch threshold, the block pulls a shared open-drain busy line low for a fixed time. If the array holds data written since the last nonvolatile cycle, and the line was really seen low, it sends a store request to the nonvolatile controller. It then keeps the line low for the length of the store.

A drop below the reset threshold, including the first power-up, leaves a recall pending. When the supply climbs back above the switch threshold, the block sends a recall request and blocks access for the restore time. While the supply is low, or while any of its own sequences runs, it raises a write-inhibit. The surrounding logic uses that inhibit to block array writes and externally requested stores.

All durations are parameters in clock cycles. The comparator flags pass through a two-flop synchroniser, and the switch flag must hold a new value for `STABLE_CYC` cycles before the block acts on it.

Top module: `supply_loss_seq`

## Requirements
- R1: A change of the switch flag that lasts fewer than `STABLE_CYC` consecutive synchronised cycles has no effect: no busy drive, no request, and the inhibit keeps its value.
- R2: While the reset flag is low, including at power-up, a recall becomes pending. When the filtered switch flag is next high, exactly one single-cycle `recall_req_o` pulse is issued. `inhibit_o` stays high for exactly `RESTORE_CYC` cycles, starting with the cycle of that pulse.
- R3: A dip below the switch threshold while the reset flag stays high leaves no recall pending, so no recall request follows the recovery.
- R4: On a supply fall with no write recorded since the last nonvolatile cycle, `busy_pull_o` is high for exactly `PULSE_CYC` cycles and no store request is issued.
- R5: On a supply fall with a recorded write, and with the busy line seen low during the pulse, exactly one `store_req_o` pulse is issued. `busy_pull_o` stays high without a break for `PULSE_CYC + STORE_CYC` cycles.
- R6: `inhibit_o` is high while the filtered switch flag is low and while any sequence of this block runs. A `wr_done_i` that arrives while `inhibit_o` is high is not recorded as a write.
- R7: If `busy_line_i` never reads low during the busy pulse, the store attempt is abandoned: no store request, and the drive is released after `PULSE_CYC` cycles.
- R8: While `inhibit_mode_i` is high, a supply fall starts no busy pulse and no store, and the pending fall event is dropped.
- R9: Requests last one cycle. No supply-fail sequence and no recall starts while `nv_busy_i` is high; the fall event waits until `nv_busy_i` is low.
- R10: Any cycle with `nv_busy_i` high clears the recorded write, so a later fall issues no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_ok_i | input | 1 | Supply above switch threshold (comparator flag) |
| rst_ok_i | input | 1 | Supply above reset threshold (comparator flag) |
| inhibit_mode_i | input | 1 | Main supply tied off: supply-loss store disabled |
| wr_done_i | input | 1 | Single-cycle pulse: an array write took place |
| nv_busy_i | input | 1 | Nonvolatile controller is running a store or recall |
| busy_line_i | input | 1 | Sampled level of the open-drain busy line |
| store_req_o | output | 1 | Single-cycle store request |
| recall_req_o | output | 1 | Single-cycle recall request |
| inhibit_o | output | 1 | Block writes and externally requested stores |
| busy_pull_o | output | 1 | Drive the busy line low when high |

## Verification
The properties assume that `inhibit_mode_i` only changes while the supply is up and no sequence runs. They also assume that `wr_done_i` is a single-cycle pulse and that `busy_line_i` reads low only when something pulls it, which the bench's line model guarantees. Each scenario task changes the mode input only between sequences, while the supply is high. Every task waits long enough for the synchroniser, the filter and the longest timer to settle before it starts the next change.

// File: rtl/supply_loss_seq.sv
module supply_loss_seq #(
  parameter int STABLE_CYC  = 4,
  parameter int PULSE_CYC   = 200,
  parameter int STORE_CYC   = 2000000,
  parameter int RESTORE_CYC = 110000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_ok_i,
  input  logic rst_ok_i,
  input  logic inhibit_mode_i,
  input  logic wr_done_i,
  input  logic nv_busy_i,
  input  logic busy_line_i,
  output logic store_req_o,
  output logic recall_req_o,
  output logic inhibit_o,
  output logic busy_pull_o
);

  localparam int DW   = $clog2(STABLE_CYC + 1);
  localparam int TM0  = (PULSE_CYC > STORE_CYC) ? PULSE_CYC : STORE_CYC;
  localparam int TMAX = (TM0 > RESTORE_CYC) ? TM0 : RESTORE_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_PULSE, S_STORE, S_RECALL} st_t;

  logic [1:0] sw_sync, rs_sync;
  logic       sw_s, rs_s, sw_q;
  logic [DW-1:0] db_cnt;
  logic [TW-1:0] tmr;
  st_t  st;
  logic recall_pend, fail_pend, dirty, seen_low;

  assign sw_s = sw_sync[1];
  assign rs_s = rs_sync[1];

  wire db_flip  = (sw_s != sw_q) && (db_cnt == DW'(STABLE_CYC - 1));
  wire sw_fall  = db_flip && sw_q;
  wire sw_rise  = db_flip && !sw_q;
  wire tmr_zero = (tmr == '0);

  wire go_recall = (st == S_IDLE) && recall_pend && sw_q && !nv_busy_i;
  wire go_pulse  = (st == S_IDLE) && fail_pend && !sw_q && !nv_busy_i && !inhibit_mode_i;
  wire go_store  = (st == S_PULSE) && tmr_zero && dirty && (seen_low || !busy_line_i);

  assign inhibit_o   = !sw_q || (st != S_IDLE);
  assign busy_pull_o = (st == S_PULSE) || (st == S_STORE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_sync <= '0;
      rs_sync <= '0;
      sw_q    <= 1'b0;
      db_cnt  <= '0;
    end else begin
      sw_sync <= {sw_sync[0], sw_ok_i};
      rs_sync <= {rs_sync[0], rst_ok_i};
      if (sw_s == sw_q) db_cnt <= '0;
      else if (db_flip) begin
        sw_q   <= sw_s;
        db_cnt <= '0;
      end else db_cnt <= db_cnt + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      recall_pend <= 1'b1;
      fail_pend   <= 1'b0;
      dirty       <= 1'b0;
    end else begin
      if (!rs_s) recall_pend <= 1'b1;
      else if (go_recall) recall_pend <= 1'b0;

      if (sw_fall) fail_pend <= 1'b1;
      else if (sw_rise || go_pulse || inhibit_mode_i) fail_pend <= 1'b0;

      if (nv_busy_i || go_store || go_recall) dirty <= 1'b0;
      else if (wr_done_i && !inhibit_o) dirty <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      tmr          <= '0;
      seen_low     <= 1'b0;
      store_req_o  <= 1'b0;
      recall_req_o <= 1'b0;
    end else begin
      store_req_o  <= 1'b0;
      recall_req_o <= 1'b0;
      if (!tmr_zero) tmr <= tmr - TW'(1);
      unique case (st)
        S_IDLE: begin
          if (go_recall) begin
            st           <= S_RECALL;
            tmr          <= TW'(RESTORE_CYC - 1);
            recall_req_o <= 1'b1;
          end else if (go_pulse) begin
            st       <= S_PULSE;
            tmr      <= TW'(PULSE_CYC - 1);
            seen_low <= 1'b0;
          end
        end
        S_PULSE: begin
          if (!busy_line_i) seen_low <= 1'b1;
          if (tmr_zero) begin
            if (go_store) begin
              st          <= S_STORE;
              tmr         <= TW'(STORE_CYC - 1);
              store_req_o <= 1'b1;
            end else st <= S_IDLE;
          end
        end
        S_STORE:  if (tmr_zero) st <= S_IDLE;
        S_RECALL: if (tmr_zero) st <= S_IDLE;
        default:  st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/supply_loss_seq_chk.sv
module supply_loss_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic inhibit_mode_i,
  input logic nv_busy_i,
  input logic store_req_o,
  input logic recall_req_o,
  input logic inhibit_o,
  input logic busy_pull_o
);

  a_r9_store_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    store_req_o |=> !store_req_o);

  a_r9_recall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req_o |=> !recall_req_o);

  a_r9_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_pull_o) |-> !$past(nv_busy_i));

  a_r5_store_under_drive: assert property (@(posedge clk) disable iff (!rst_n)
    store_req_o |-> busy_pull_o);

  a_r6_drive_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
    busy_pull_o |-> inhibit_o);

  a_r2_recall_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req_o |-> inhibit_o && !busy_pull_o);

  a_r8_mode_blocks_drive: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_mode_i && $past(inhibit_mode_i) && !$past(busy_pull_o) |-> !busy_pull_o);

  a_r5_no_dual_request: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_req_o && recall_req_o));

endmodule

bind supply_loss_seq supply_loss_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .inhibit_mode_i(inhibit_mode_i), .nv_busy_i(nv_busy_i),
  .store_req_o(store_req_o), .recall_req_o(recall_req_o),
  .inhibit_o(inhibit_o), .busy_pull_o(busy_pull_o)
);

// File: tb/supply_loss_seq_tb_top.sv
`timescale 1ns/1ps
module supply_loss_seq_tb_top;
  localparam int STB = 4, PUL = 20, STO = 200, RES = 100;

  logic clk = 0, rst_n = 0;
  logic sw_ok = 0, rst_ok = 0, imode = 0, wr = 0, nvb = 0, hold_high = 0;
  logic store_req, recall_req, inhibit, busy_pull, line;
  int checks = 0, fails = 0;
  int n_store = 0, n_recall = 0, n_busy = 0, n_inh_after_rec = 0;
  logic rec_seen = 0;

  always #2.5 clk = ~clk;
  assign line = hold_high ? 1'b1 : ~busy_pull;

  supply_loss_seq #(.STABLE_CYC(STB), .PULSE_CYC(PUL), .STORE_CYC(STO), .RESTORE_CYC(RES)) dut_i (
    .clk(clk), .rst_n(rst_n), .sw_ok_i(sw_ok), .rst_ok_i(rst_ok), .inhibit_mode_i(imode),
    .wr_done_i(wr), .nv_busy_i(nvb), .busy_line_i(line), .store_req_o(store_req),
    .recall_req_o(recall_req), .inhibit_o(inhibit), .busy_pull_o(busy_pull));

  always @(negedge clk) if (rst_n) begin
    if (store_req) n_store++;
    if (recall_req) begin n_recall++; rec_seen = 1; end
    if (busy_pull) n_busy++;
    if (rec_seen && inhibit) n_inh_after_rec++;
    if (rec_seen && !inhibit) rec_seen = 0;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    n_store = 0; n_recall = 0; n_busy = 0; n_inh_after_rec = 0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write();
    @(negedge clk); wr = 1; @(negedge clk); wr = 0;
  endtask

  task automatic t_reset();
    #1;
    chk("R6 reset inhibit", inhibit, 1);
    chk("R9 reset store", store_req, 0);
    chk("R9 reset recall", recall_req, 0);
    chk("R4 reset drive", busy_pull, 0);
  endtask

  task automatic t_powerup();
    cyc(3); rst_n = 1; cyc(5); clr();
    rst_ok = 1; sw_ok = 1; cyc(RES + 40);
    chk("R2 recall count", n_recall, 1);
    chk("R2 inhibit length", n_inh_after_rec, RES);
    chk("R2 inhibit released", inhibit, 0);
  endtask

  task automatic t_glitch();
    clr(); sw_ok = 0; cyc(2); sw_ok = 1; cyc(30);
    chk("R1 glitch drive", n_busy, 0);
    chk("R1 glitch inhibit", inhibit, 0);
  endtask

  task automatic t_brownout();
    clr(); sw_ok = 0; cyc(60);
    chk("R4 pulse length", n_busy, PUL);
    chk("R4 no store", n_store, 0);
    chk("R6 low supply inhibit", inhibit, 1);
    do_write();
    sw_ok = 1; cyc(40);
    chk("R3 no recall", n_recall, 0);
    chk("R3 inhibit off", inhibit, 0);
    clr(); sw_ok = 0; cyc(60); sw_ok = 1; cyc(30);
    chk("R6 low write ignored", n_store, 0);
  endtask

  task automatic t_deep();
    clr(); sw_ok = 0; cyc(30); rst_ok = 0; cyc(20); rst_ok = 1; cyc(5); sw_ok = 1;
    cyc(RES + 40);
    chk("R2 deep recall", n_recall, 1);
  endtask

  task automatic t_store();
    do_write(); clr(); sw_ok = 0; cyc(PUL + STO + 50);
    chk("R5 store count", n_store, 1);
    chk("R5 drive length", n_busy, PUL + STO);
    sw_ok = 1; cyc(30);
  endtask

  task automatic t_held_high();
    do_write(); hold_high = 1; clr(); sw_ok = 0; cyc(PUL + 50);
    chk("R7 no store", n_store, 0);
    chk("R7 drive length", n_busy, PUL);
    chk("R7 released", busy_pull, 0);
    hold_high = 0; sw_ok = 1; cyc(30);
  endtask

  task automatic t_mode();
    imode = 1; cyc(2); clr(); sw_ok = 0; cyc(60);
    chk("R8 no drive", n_busy, 0);
    chk("R8 no store", n_store, 0);
    chk("R6 mode inhibit", inhibit, 1);
    sw_ok = 1; cyc(30); imode = 0; cyc(2);
  endtask

  task automatic t_busy();
    nvb = 1; clr(); sw_ok = 0; cyc(50);
    chk("R9 held while busy", n_busy, 0);
    nvb = 0; cyc(PUL + STO + 30);
    chk("R9 starts after busy", n_busy, PUL);
    chk("R10 dirty cleared", n_store, 0);
    sw_ok = 1; cyc(30);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_glitch();
    t_brownout();
    t_deep();
    t_store();
    t_held_high();
    t_mode();
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule